// File: doc/BRIEF.md
# I2S Master Audio Serializer

This block sends stereo PCM samples over a three-wire serial audio link and acts as the bus master. It divides the system clock by a programmable integer to make the bit clock. It drives the word-select line, which marks the channel, and the serial data line, which carries the sample bits most significant bit first. Upstream logic offers one left/right sample pair at a time on a valid/ready handshake. A one-pair holding register sits in front of the frame shifter, so the next pair can arrive while the current frame is still being shifted out. Frames follow each other with no gap.

Two run-time controls shape each frame. One chooses which channel goes first. The other chooses the data alignment: the first data bit can appear on the same bit-clock period as the word-select change, or one period later in the Philips style. The divisor and both controls are captured only at frame starts, so a frame never mixes two settings. If no fresh pair is waiting when a frame starts, the last pair is sent again and a one-cycle underrun pulse is raised.

Top module: `audio_serial_tx`

## Requirements
- R1: The bit clock `bclk` repeats every M system clocks, where M is `divM`. A `divM` value below 2 acts as 2. In each period `bclk` is low for floor(M/2) cycles and high for the rest.
- R2: While enabled, `ws` and `sd` change only on the system clock edge where `bclk` goes from 1 to 0.
- R3: A frame is 2×SAMPLE_W bit periods. It holds two back-to-back channel slots of SAMPLE_W periods each, and each slot carries its word most significant bit first.
- R4: `ws` is 0 during the left slot and 1 during the right slot. With `rightFirst` = 1 the right slot comes first in the frame; with `rightFirst` = 0 the left slot comes first.
- R5: With `msbShift` = 0, a slot's MSB is on `sd` in the same bit period in which `ws` takes that slot's value.
- R6: With `msbShift` = 1, `sd` lags the `msbShift` = 0 stream by exactly one bit period. This puts each slot's LSB in the first period of the next slot. The first period after enable carries 0.
- R7: `inReady` is high exactly when the holding register is empty. A pair is taken on a clock edge with `inValid` and `inReady` both high. After that `inReady` stays low until the pair moves into the shifter at the next frame start.
- R8: If the holding register is empty at a frame start, the previous pair is sent again and `underrun` is high for exactly one system clock. After reset the previous pair is all zeros.
- R9: `divM`, `rightFirst` and `msbShift` are sampled only at a frame start, while `enable` is low, or during reset. A change in the middle of a frame leaves the rest of that frame unchanged.
- R10: During reset, and while `enable` is low, `bclk`, `ws`, `sd` and `underrun` are 0. Reset also empties the holding register. After enable, the first falling edge of `bclk` starts bit period 0 of a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the bit clock and frame sequencer |
| divM | input | DIV_W | Bit-clock divisor (values below 2 act as 2) |
| rightFirst | input | 1 | 1: right slot leads each frame |
| msbShift | input | 1 | 1: data lags word select by one bit period |
| inValid | input | 1 | Sample pair offered |
| inReady | output | 1 | Holding register empty |
| inLeft | input | SAMPLE_W | Left-channel sample |
| inRight | input | SAMPLE_W | Right-channel sample |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select (0 left, 1 right) |
| sd | output | 1 | Serial data |
| underrun | output | 1 | One-cycle pulse when a frame repeats the last pair |

## Verification
The bench builds the block with SAMPLE_W = 8 and DIV_W = 4. A frame is then only 16 bit periods, so a full frame plus the first period of the next fits in each test. The 4-bit divisor field can hold the values 0 and 1 that must clamp to 2, as well as odd divisors such as 3 and 7 that make the high and low phases unequal. The short frames also keep the continuous two-pair test, the underrun repeat and the mid-frame control change within a few hundred bit periods.

// File: rtl/aser_pkg.sv
package aser_pkg;

  // Strobes from the sequencer to the datapath, valid in the cycle they are high.
  typedef struct packed {
    logic fallTick;    // bclk falls on this edge; a new bit period starts
    logic frameStart;  // the bit period starting now is period 0 of a frame
    logic secondSlot;  // the bit period starting now belongs to the second slot
    logic firstRight;  // active channel order for the period starting now
    logic msbDelay;    // active alignment for the period starting now
  } aser_stb_t;

endpackage

// File: rtl/aser_ctrl.sv
module aser_ctrl
  import aser_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int DIV_W    = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [DIV_W-1:0] divM,
  input  logic             rightFirst,
  input  logic             msbShift,
  output aser_stb_t        stb,
  output logic             bclk
);

  localparam int FRAME = 2 * SAMPLE_W;
  localparam int POS_W = $clog2(FRAME);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME - 1);
  localparam logic [POS_W-1:0] SLOT_POS = POS_W'(SAMPLE_W);
  localparam logic [DIV_W-1:0] MIN_DIV  = DIV_W'(2);

  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] cfgM;
  logic [DIV_W-1:0] clampM;
  logic [DIV_W-1:0] halfM;
  logic [POS_W-1:0] pos;
  logic [POS_W-1:0] posNext;
  logic             cfgRight;
  logic             cfgMsb;
  logic             bclkQ;
  logic             riseTick;
  logic             fallTick;
  logic             frameStart;

  assign clampM     = (divM < MIN_DIV) ? MIN_DIV : divM;
  assign halfM      = cfgM >> 1;
  assign riseTick   = enable && (divCnt == halfM - DIV_W'(1));
  assign fallTick   = enable && (divCnt == cfgM - DIV_W'(1));
  assign frameStart = fallTick && (pos == LAST_POS);
  assign posNext    = frameStart ? '0 : pos + POS_W'(1);

  always_comb begin
    stb.fallTick   = fallTick;
    stb.frameStart = frameStart;
    stb.secondSlot = (posNext >= SLOT_POS);
    stb.firstRight = frameStart ? rightFirst : cfgRight;
    stb.msbDelay   = frameStart ? msbShift   : cfgMsb;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      divCnt   <= '0;
      pos      <= LAST_POS;
      bclkQ    <= 1'b0;
      cfgM     <= clampM;
      cfgRight <= rightFirst;
      cfgMsb   <= msbShift;
    end else begin
      divCnt <= fallTick ? '0 : divCnt + DIV_W'(1);
      if (riseTick) bclkQ <= 1'b1;
      if (fallTick) begin
        bclkQ <= 1'b0;
        pos   <= posNext;
      end
      if (frameStart) begin
        cfgM     <= clampM;
        cfgRight <= rightFirst;
        cfgMsb   <= msbShift;
      end
    end
  end

  assign bclk = bclkQ;

  // R1
  min_div_chk: assert property (@(posedge clk) disable iff (rst)
    cfgM >= MIN_DIV);

  // R1
  div_range_chk: assert property (@(posedge clk) disable iff (rst)
    divCnt < cfgM);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (enable && $past(enable) && !$past(rst) && !$past(frameStart))
      |-> ($stable(cfgM) && $stable(cfgRight) && $stable(cfgMsb)));

endmodule

// File: rtl/aser_data.sv
module aser_data
  import aser_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  aser_stb_t           stb,
  input  logic                inValid,
  output logic                inReady,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  output logic                ws,
  output logic                sd,
  output logic                underrun
);

  localparam int FRAME = 2 * SAMPLE_W;

  logic [SAMPLE_W-1:0] holdL, holdR;
  logic [SAMPLE_W-1:0] curL, curR;
  logic [SAMPLE_W-1:0] nextL, nextR;
  logic [FRAME-1:0]    frameSr;
  logic [FRAME-1:0]    newFrame;
  logic                holdFull;
  logic                accept;
  logic                loadNow;
  logic                nextBit;
  logic                prevBit;
  logic                wsQ, sdQ, underrunQ;

  assign inReady  = !holdFull;
  assign accept   = inValid && !holdFull;
  assign loadNow  = enable && stb.fallTick && stb.frameStart;
  assign nextL    = holdFull ? holdL : curL;
  assign nextR    = holdFull ? holdR : curR;
  assign newFrame = stb.firstRight ? {nextR, nextL} : {nextL, nextR};
  assign nextBit  = stb.frameStart ? newFrame[FRAME-1] : frameSr[FRAME-1];

  // Holding register and the pair kept for repeats.
  always_ff @(posedge clk) begin
    if (rst) begin
      holdL    <= '0;
      holdR    <= '0;
      holdFull <= 1'b0;
      curL     <= '0;
      curR     <= '0;
    end else begin
      if (accept) begin
        holdL <= inLeft;
        holdR <= inRight;
      end
      holdFull <= (holdFull && !loadNow) || accept;
      if (loadNow) begin
        curL <= nextL;
        curR <= nextR;
      end
    end
  end

  // Frame shifter and registered bus outputs.
  always_ff @(posedge clk) begin
    if (rst) begin
      frameSr   <= '0;
      prevBit   <= 1'b0;
      wsQ       <= 1'b0;
      sdQ       <= 1'b0;
      underrunQ <= 1'b0;
    end else if (!enable) begin
      prevBit   <= 1'b0;
      wsQ       <= 1'b0;
      sdQ       <= 1'b0;
      underrunQ <= 1'b0;
    end else begin
      underrunQ <= loadNow && !holdFull;
      if (stb.fallTick) begin
        frameSr <= stb.frameStart ? (newFrame << 1) : (frameSr << 1);
        prevBit <= nextBit;
        sdQ     <= stb.msbDelay ? prevBit : nextBit;
        wsQ     <= stb.firstRight ^ stb.secondSlot;
      end
    end
  end

  assign ws       = wsQ;
  assign sd       = sdQ;
  assign underrun = underrunQ;

  // R7
  accept_block_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && inReady) |=> !inReady);

  // R8
  underrun_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |=> !underrun);

  // R8
  underrun_cause_chk: assert property (@(posedge clk) disable iff (rst)
    underrun |-> $past(inReady));

endmodule

// File: rtl/audio_serial_tx.sv
module audio_serial_tx
  import aser_pkg::*;
#(
  parameter int SAMPLE_W = 16,
  parameter int DIV_W    = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic [DIV_W-1:0]    divM,
  input  logic                rightFirst,
  input  logic                msbShift,
  input  logic                inValid,
  output logic                inReady,
  input  logic [SAMPLE_W-1:0] inLeft,
  input  logic [SAMPLE_W-1:0] inRight,
  output logic                bclk,
  output logic                ws,
  output logic                sd,
  output logic                underrun
);

  aser_stb_t stb;

  aser_ctrl #(.SAMPLE_W(SAMPLE_W), .DIV_W(DIV_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .divM       (divM),
    .rightFirst (rightFirst),
    .msbShift   (msbShift),
    .stb        (stb),
    .bclk       (bclk)
  );

  aser_data #(.SAMPLE_W(SAMPLE_W)) u_data (
    .clk      (clk),
    .rst      (rst),
    .enable   (enable),
    .stb      (stb),
    .inValid  (inValid),
    .inReady  (inReady),
    .inLeft   (inLeft),
    .inRight  (inRight),
    .ws       (ws),
    .sd       (sd),
    .underrun (underrun)
  );

  // R2
  ws_edge_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(enable) && !$past(rst) && !$stable(ws)) |-> $fell(bclk));

  // R2
  sd_edge_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(enable) && !$past(rst) && !$stable(sd)) |-> $fell(bclk));

  // R10
  idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(enable) && !$past(rst)) |-> (!bclk && !ws && !sd && !underrun));

endmodule

// File: tb/audio_serial_tx_tb.sv
module audio_serial_tx_tb;

  localparam int W  = 8;
  localparam int DW = 4;
  localparam int FW = 2 * W;
  localparam int NV = 7;

  // {divM[25:22], rightFirst[21], msbShift[20], left[19:12], right[11:4], expected period[3:0]}
  localparam logic [25:0] VEC [NV] = '{
    {4'd2, 1'b0, 1'b0, 8'hA5, 8'h3C, 4'd2},
    {4'd2, 1'b1, 1'b0, 8'h81, 8'h7E, 4'd2},
    {4'd3, 1'b0, 1'b1, 8'hF0, 8'h0F, 4'd3},
    {4'd4, 1'b1, 1'b1, 8'hC3, 8'h5A, 4'd4},
    {4'd1, 1'b0, 1'b1, 8'h01, 8'h80, 4'd2},
    {4'd0, 1'b1, 1'b0, 8'hFF, 8'h00, 4'd2},
    {4'd7, 1'b0, 1'b0, 8'h96, 8'h69, 4'd7}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          enable = 1'b0;
  logic [DW-1:0] divM = '0;
  logic          rightFirst = 1'b0;
  logic          msbShift = 1'b0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [W-1:0]  inLeft = '0;
  logic [W-1:0]  inRight = '0;
  logic          bclk, ws, sd, underrun;

  always #10 clk = ~clk;

  audio_serial_tx #(.SAMPLE_W(W), .DIV_W(DW)) u_dut (
    .clk(clk), .rst(rst), .enable(enable), .divM(divM),
    .rightFirst(rightFirst), .msbShift(msbShift),
    .inValid(inValid), .inReady(inReady), .inLeft(inLeft), .inRight(inRight),
    .bclk(bclk), .ws(ws), .sd(sd), .underrun(underrun)
  );

  int   checks = 0;
  int   fails = 0;
  int   cyc = 0;
  int   riseTotal = 0;
  int   urTotal = 0;
  logic bclkPrev = 1'b0;
  logic wsLog [1024];
  logic sdLog [1024];
  int   cycLog [1024];

  // Monitor: log ws/sd at each bclk rising edge, away from the active edge.
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (bclk && !bclkPrev) begin
      wsLog[riseTotal % 1024]  = ws;
      sdLog[riseTotal % 1024]  = sd;
      cycLog[riseTotal % 1024] = cyc;
      riseTotal = riseTotal + 1;
    end
    bclkPrev = bclk;
    if (underrun) urTotal = urTotal + 1;
    if (cyc == 100000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog (R1..) actual cycles=%0d expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(string tag, int act, int exp);
    checks = checks + 1;
    if (act != exp) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic expSd(logic [W-1:0] l, logic [W-1:0] r, logic rf, logic ms, int p);
    logic [FW-1:0] s;
    s = rf ? {r, l} : {l, r};
    if (ms) begin
      if (p == 0) return 1'b0;
      return s[FW-1-((p-1) % FW)];
    end
    return s[FW-1-(p % FW)];
  endfunction

  function automatic logic expWs(logic rf, int p);
    return rf ^ ((p % FW) >= W);
  endfunction

  task automatic pushPair(logic [W-1:0] l, logic [W-1:0] r);
    @(negedge clk);
    inValid = 1'b1; inLeft = l; inRight = r;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic waitRises(int target);
    while (riseTotal < target) @(negedge clk);
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; enable = 1'b0; inValid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    int base, ub, wsBad, sdBad;
    logic [W-1:0] l, r;
    logic rf, ms;

    // R10: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R10 reset outputs {bclk,ws,sd,underrun,inReady}",
          {27'd0, bclk, ws, sd, underrun, inReady}, 32'b00001);

    // Table of configurations walked by one loop.
    for (int v = 0; v < NV; v++) begin
      l = VEC[v][19:12]; r = VEC[v][11:4];
      rf = VEC[v][21];   ms = VEC[v][20];
      doReset();
      divM = VEC[v][25:22]; rightFirst = rf; msbShift = ms;
      pushPair(l, r);
      check($sformatf("R7 inReady low with held pair v%0d", v), int'(inReady), 0);
      base = riseTotal; ub = urTotal;
      enable = 1'b1;
      waitRises(base + FW + 2);
      wsBad = 0; sdBad = 0;
      for (int p = 0; p <= FW; p++) begin
        if (wsLog[(base + 1 + p) % 1024] !== expWs(rf, p)) wsBad++;
        if (sdLog[(base + 1 + p) % 1024] !== expSd(l, r, rf, ms, p)) sdBad++;
      end
      check($sformatf("R4 ws slot order mismatches v%0d", v), wsBad, 0);
      check($sformatf("R3 R5 R6 sd bit mismatches v%0d", v), sdBad, 0);
      check($sformatf("R1 bclk period v%0d", v),
            cycLog[(base + 2) % 1024] - cycLog[(base + 1) % 1024], int'(VEC[v][3:0]));
      check($sformatf("R8 underrun pulses on repeat v%0d", v), urTotal - ub, 1);
      enable = 1'b0;
    end

    // R7 R8: continuous frames from two pairs, no underrun
    doReset();
    divM = 4'd2; rightFirst = 1'b0; msbShift = 1'b0;
    pushPair(8'h11, 8'h22);
    base = riseTotal; ub = urTotal;
    enable = 1'b1;
    while (!inReady) @(negedge clk);
    pushPair(8'h33, 8'hC4);
    waitRises(base + 2 * FW);
    check("R8 no underrun across back-to-back pairs", urTotal - ub, 0);
    waitRises(base + 2 * FW + 1);
    wsBad = 0; sdBad = 0;
    for (int p = 0; p < FW; p++) begin
      if (sdLog[(base + 1 + p) % 1024] !== expSd(8'h11, 8'h22, 1'b0, 1'b0, p)) wsBad++;
      if (sdLog[(base + 1 + FW + p) % 1024] !== expSd(8'h33, 8'hC4, 1'b0, 1'b0, p)) sdBad++;
    end
    check("R7 first pair frame bits", wsBad, 0);
    check("R7 second pair frame bits", sdBad, 0);
    enable = 1'b0;

    // R9: channel order changed mid-frame applies only from the next frame
    doReset();
    divM = 4'd2; rightFirst = 1'b0; msbShift = 1'b0;
    pushPair(8'hAA, 8'h55);
    base = riseTotal;
    enable = 1'b1;
    waitRises(base + 4);
    rightFirst = 1'b1;
    waitRises(base + FW + 2);
    wsBad = 0;
    for (int p = 0; p < FW; p++)
      if (wsLog[(base + 1 + p) % 1024] !== expWs(1'b0, p)) wsBad++;
    check("R9 ws of running frame unchanged", wsBad, 0);
    check("R9 next frame ws uses new order", int'(wsLog[(base + 1 + FW) % 1024]), 1);
    check("R9 next frame leads with right MSB", int'(sdLog[(base + 1 + FW) % 1024]), 0);

    // R10: disabling returns the bus to idle
    enable = 1'b0;
    repeat (6) @(negedge clk);
    check("R10 idle outputs after disable {bclk,ws,sd}", {29'd0, bclk, ws, sd}, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule